// File: doc/BRIEF.md
# Code-Density Calibration Table Generator

This block turns a stream of raw fine-time codes into the lookup table that maps each code to a calibrated fraction of the coarse clock period. During a calibration run, a delay line is fed with hits that have no relation to the sampling clock. The block counts how many hits land on each raw code. The number of hits on a code is proportional to the time span that code covers. Once a fixed, power-of-two number of samples has been collected, the block walks through the codes in ascending order. For each code it writes the running total of the spans up to and including that code, scaled so that the full set of spans equals one clock period.

A run begins when `start` is pulsed. That pulse clears every histogram counter and drops `done`. After that, one code is taken on each cycle in which `code_valid` is high. When the last sample has been taken, the block writes one table entry per cycle through a plain memory write port and then raises `done`. A new `start` may arrive at any point. It abandons the run in progress, and the next complete run overwrites the whole table. This allows calibration to be repeated periodically while the chip is in use.

Top module: `density_cal_table`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `done` and `tbl_we` are both low.
- R2: A `start` pulse clears all histogram counts and drops `done` on the following cycle. Samples taken before the pulse, including those of an abandoned run, have no effect on the table that is later written.
- R3: Exactly 2^LOG_SAMPLES codes are accepted per run, one per cycle with `code_valid` high. The first table write appears two cycles after the cycle that supplied the last accepted code.
- R4: A run writes 2^CODE_W entries on consecutive cycles with `tbl_we` high, at addresses 0, 1, 2, ... in ascending order.
- R5: The entry at address n equals floor(C_n x 2^FRAC_W / 2^LOG_SAMPLES), limited to 2^FRAC_W - 1, where C_n is the number of accepted codes whose value is n or less. The entries therefore never decrease along the address order.
- R6: A code that was never hit adds nothing. Its entry equals the entry before it, and unseen codes below the lowest hit code read 0.
- R7: `done` rises the cycle after the write to the last address, stays high until the next `start`, and no write occurs while it is high.
- R8: Codes presented with `code_valid` low, or while the block is writing or has finished, are not counted.
- R9: Every completed run replaces every table entry. A later run with a different code distribution yields that distribution's table, and a run abandoned during its write phase leaves no trace in the next run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that begins a new calibration run |
| code_valid | input | 1 | `code_in` carries a sample this cycle |
| code_in | input | CODE_W | Raw fine code from the delay-line encoder |
| tbl_we | output | 1 | Table write enable |
| tbl_addr | output | CODE_W | Table write address, equal to the raw code |
| tbl_data | output | FRAC_W | Calibrated cumulative fraction of the clock period |
| done | output | 1 | Table fully written; held until the next `start` |

## Verification
The bench runs the main function against several input patterns. A uniform spread over a middle band of codes, with idle cycles mixed in, checks the scaling against a known ramp and shows that empty codes at both ends keep a flat table. A distribution with heavy periodic bins makes a fault in the running sum appear as a step in the wrong place. Feeding every hit to a single code drives the sum to a full period, which checks the clamp and shows that neighbouring codes are not mixed up. The code 127 exercises the last address. Further runs restart during accumulation and during the write phase, so that counts left over from an old run would appear as nonzero entries where the new run expects zeros.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ACCUM = 3'd1,
    PH_WRITE = 3'd2,
    PH_DRAIN = 3'd3,
    PH_DONE  = 3'd4
  } phase_t;

  // Cumulative count -> fraction of a period, floor-scaled, clamped to full scale minus one.
  function automatic logic [31:0] cum_to_frac(input logic [31:0] cum,
                                              input int unsigned log_n,
                                              input int unsigned frac_w);
    logic [47:0] prod;
    logic [47:0] q;
    logic [47:0] top;
    prod = {16'd0, cum} << frac_w;
    q    = prod >> log_n;
    top  = (48'd1 << frac_w) - 48'd1;
    if (q > top) q = top;
    return q[31:0];
  endfunction

endpackage

// File: rtl/cdt_ctrl.sv
module cdt_ctrl
  import cdt_pkg::*;
#(
  parameter int CODE_W      = 7,
  parameter int LOG_SAMPLES = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              code_valid,
  output phase_t            phase,
  output logic              accept,
  output logic              last_sample,
  output logic              write_step,
  output logic              last_idx,
  output logic [CODE_W-1:0] idx
);

  localparam int SCNT_W = LOG_SAMPLES;

  logic [SCNT_W-1:0] sample_cnt;

  assign accept      = (phase == PH_ACCUM) && code_valid && !start;
  assign last_sample = accept && (sample_cnt == {SCNT_W{1'b1}});
  assign write_step  = (phase == PH_WRITE) && !start;
  assign last_idx    = write_step && (idx == {CODE_W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      sample_cnt <= '0;
      idx        <= '0;
    end else if (start) begin
      phase      <= PH_ACCUM;
      sample_cnt <= '0;
      idx        <= '0;
    end else begin
      unique case (phase)
        PH_ACCUM: begin
          if (accept) sample_cnt <= sample_cnt + 1'b1;
          if (last_sample) phase <= PH_WRITE;
        end
        PH_WRITE: begin
          if (write_step) idx <= idx + 1'b1;
          if (last_idx) phase <= PH_DRAIN;
        end
        PH_DRAIN: phase <= PH_DONE;
        default:  phase <= phase;
      endcase
    end
  end

endmodule

// File: rtl/cdt_hist_bank.sv
module cdt_hist_bank #(
  parameter int CODE_W = 7,
  parameter int CNT_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              inc_en,
  input  logic [CODE_W-1:0] inc_code,
  input  logic [CODE_W-1:0] rd_idx,
  output logic [CNT_W-1:0]  rd_count
);

  localparam int NUM_BINS = 1 << CODE_W;

  logic [CNT_W-1:0] bin_val [NUM_BINS];

  for (genvar g = 0; g < NUM_BINS; g++) begin : g_bin
    logic [CNT_W-1:0] cnt_q;
    logic             hit;
    assign hit = inc_en && (inc_code == CODE_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                cnt_q <= '0;
      else if (clear)                            cnt_q <= '0;
      else if (hit && (cnt_q != {CNT_W{1'b1}}))  cnt_q <= cnt_q + 1'b1;
    end
    assign bin_val[g] = cnt_q;
  end

  assign rd_count = bin_val[rd_idx];

endmodule

// File: rtl/cdt_cum_writer.sv
module cdt_cum_writer
  import cdt_pkg::*;
#(
  parameter int CODE_W      = 7,
  parameter int LOG_SAMPLES = 12,
  parameter int FRAC_W      = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  input  logic [CODE_W-1:0] idx,
  input  logic [LOG_SAMPLES:0] bin_count,
  output logic              wr_en,
  output logic [CODE_W-1:0] wr_addr,
  output logic [FRAC_W-1:0] wr_data
);

  localparam int SUM_W = LOG_SAMPLES + 2;

  logic [SUM_W-1:0]  cum_q;
  logic [SUM_W-1:0]  cum_next;
  logic [FRAC_W-1:0] frac_next;

  assign cum_next  = cum_q + SUM_W'(bin_count);
  assign frac_next = FRAC_W'(cum_to_frac(32'(cum_next), LOG_SAMPLES, FRAC_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cum_q   <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else if (clear) begin
      cum_q   <= '0;
      wr_en   <= 1'b0;
    end else if (step) begin
      cum_q   <= cum_next;
      wr_en   <= 1'b1;
      wr_addr <= idx;
      wr_data <= frac_next;
    end else begin
      wr_en   <= 1'b0;
    end
  end

endmodule

// File: rtl/density_cal_table.sv
module density_cal_table
  import cdt_pkg::*;
#(
  parameter int CODE_W      = 7,
  parameter int LOG_SAMPLES = 12,
  parameter int FRAC_W      = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              code_valid,
  input  logic [CODE_W-1:0] code_in,
  output logic              tbl_we,
  output logic [CODE_W-1:0] tbl_addr,
  output logic [FRAC_W-1:0] tbl_data,
  output logic              done
);

  localparam int CNT_W = LOG_SAMPLES + 1;

  phase_t            phase;
  logic              accept_evt;
  logic              last_sample_evt;
  logic              write_step_evt;
  logic              last_idx_evt;
  logic [CODE_W-1:0] walk_idx;
  logic [CNT_W-1:0]  bin_count;

  cdt_ctrl #(.CODE_W(CODE_W), .LOG_SAMPLES(LOG_SAMPLES)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .code_valid  (code_valid),
    .phase       (phase),
    .accept      (accept_evt),
    .last_sample (last_sample_evt),
    .write_step  (write_step_evt),
    .last_idx    (last_idx_evt),
    .idx         (walk_idx)
  );

  cdt_hist_bank #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (start),
    .inc_en   (accept_evt),
    .inc_code (code_in),
    .rd_idx   (walk_idx),
    .rd_count (bin_count)
  );

  cdt_cum_writer #(.CODE_W(CODE_W), .LOG_SAMPLES(LOG_SAMPLES), .FRAC_W(FRAC_W)) u_wr (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (start),
    .step      (write_step_evt),
    .idx       (walk_idx),
    .bin_count (bin_count),
    .wr_en     (tbl_we),
    .wr_addr   (tbl_addr),
    .wr_data   (tbl_data)
  );

  assign done = (phase == PH_DONE);

endmodule

// File: rtl/density_cal_table_chk.sv
module density_cal_table_chk #(
  parameter int CODE_W = 7,
  parameter int FRAC_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              tbl_we,
  input logic [CODE_W-1:0] tbl_addr,
  input logic [FRAC_W-1:0] tbl_data,
  input logic              done,
  input logic              last_sample_evt,
  input logic              last_idx_evt
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> (!done && !tbl_we));

  // R2
  start_drops_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done);

  // R3
  first_write_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tbl_we) |-> $past(last_sample_evt, 2));

  // R4
  first_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tbl_we) |-> (tbl_addr == '0));

  // R4
  addr_ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_we && $past(tbl_we)) |-> (tbl_addr == $past(tbl_addr) + 1'b1));

  // R5
  entry_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_we && $past(tbl_we)) |-> (tbl_data >= $past(tbl_data)));

  // R7
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !tbl_we);

  // R7
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_idx_evt && !start) |=> ##1 (!start -> done));

endmodule

bind density_cal_table density_cal_table_chk #(.CODE_W(CODE_W), .FRAC_W(FRAC_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .start           (start),
  .tbl_we          (tbl_we),
  .tbl_addr        (tbl_addr),
  .tbl_data        (tbl_data),
  .done            (done),
  .last_sample_evt (last_sample_evt),
  .last_idx_evt    (last_idx_evt)
);

// File: tb/sim_density_cal_table.sv
`timescale 1ns/1ps
module sim_density_cal_table;

  localparam int CODE_W = 7;
  localparam int LOG_N  = 12;
  localparam int FRAC_W = 10;
  localparam int NBINS  = 1 << CODE_W;
  localparam int NSAMP  = 1 << LOG_N;
  localparam int FULL   = 1 << FRAC_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic              code_valid = 1'b0;
  logic [CODE_W-1:0] code_in = '0;
  logic              tbl_we;
  logic [CODE_W-1:0] tbl_addr;
  logic [FRAC_W-1:0] tbl_data;
  logic              done;

  always #2 clk = ~clk;

  density_cal_table #(.CODE_W(CODE_W), .LOG_SAMPLES(LOG_N), .FRAC_W(FRAC_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .code_valid(code_valid), .code_in(code_in),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_data(tbl_data), .done(done)
  );

  int          checks = 0;
  int          errors = 0;
  bit          finished = 0;
  int unsigned hist [NBINS];
  int          got [NBINS];
  int          got_cnt = 0;
  int          seq_err = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Records every table write; address order is the R4 concern.
  always @(negedge clk) begin
    if (tbl_we) begin
      if (got_cnt < NBINS) begin
        if (int'(tbl_addr) != got_cnt) seq_err++;
        got[got_cnt] = int'(tbl_data);
      end
      got_cnt++;
    end
  end

  function automatic int expect_entry(input int n);
    longint cum = 0;
    longint v;
    for (int i = 0; i <= n; i++) cum += hist[i];
    v = (cum * FULL) / NSAMP;
    if (v > FULL - 1) v = FULL - 1;
    return int'(v);
  endfunction

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    code_valid = 1'b1;
    code_in = CODE_W'($urandom);
    @(negedge clk);
    start = 1'b0;
    code_valid = 1'b0;
    got_cnt = 0;
    seq_err = 0;
    for (int i = 0; i < NBINS; i++) hist[i] = 0;
  endtask

  function automatic int pick_code(input int mode);
    int r;
    case (mode)
      0: return 20 + int'($urandom % 80);
      1: begin
        r = int'($urandom % 3);
        if (r == 0) return 16 * int'($urandom % 8);
        return int'($urandom % NBINS);
      end
      2: return 64;
      3: return NBINS - 1;
      default: return int'($urandom % NBINS);
    endcase
  endfunction

  // Feeds exactly NSAMP valid codes with idle cycles mixed in (R8), then checks write timing (R3).
  task automatic feed_run(input int mode);
    int c;
    for (int i = 0; i < NSAMP; i++) begin
      if (($urandom % 8) == 0) begin
        @(negedge clk);
        code_valid = 1'b0;
        code_in = CODE_W'($urandom);
      end
      c = pick_code(mode);
      @(negedge clk);
      code_valid = 1'b1;
      code_in = CODE_W'(c);
      hist[c]++;
    end
    @(negedge clk);
    code_valid = 1'b1;
    code_in = CODE_W'(0);
    chk(tbl_we == 1'b0, "R3", "no write one cycle after last sample", tbl_we, 0);
    @(negedge clk);
    code_in = CODE_W'(NBINS - 1);
    chk(tbl_we == 1'b1 && tbl_addr == '0, "R3", "first write two cycles after last sample",
        {tbl_we, tbl_addr}, {1'b1, 7'd0});
  endtask

  task automatic finish_run(input string tag);
    int guard = 0;
    // Valid codes keep arriving during the write phase and after it (R8).
    while (!done && guard < 400) begin
      @(negedge clk);
      code_valid = 1'b1;
      code_in = CODE_W'($urandom);
      guard++;
    end
    code_valid = 1'b0;
    chk(done == 1'b1, "R7", {tag, " done raised"}, done, 1);
    chk(got_cnt == NBINS, "R4", {tag, " write count"}, got_cnt, NBINS);
    chk(seq_err == 0, "R4", {tag, " ascending addresses"}, seq_err, 0);
    for (int n = 0; n < NBINS; n++)
      chk(got[n] == expect_entry(n), "R5", {tag, $sformatf(" entry %0d", n)}, got[n], expect_entry(n));
    repeat (3) @(negedge clk);
    chk(done == 1'b1 && tbl_we == 1'b0, "R7", {tag, " done held, no writes"}, {done, tbl_we}, 2);
  endtask

  initial begin
    int d;
    void'($urandom(32'h5eed_0c0d));
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && tbl_we == 1'b0, "R1", "outputs quiet in reset", {done, tbl_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 1'b0 && tbl_we == 1'b0, "R1", "outputs quiet after reset", {done, tbl_we}, 0);

    // Uniform over 20..99: flat ends (R6), ramp within tolerance (R5).
    pulse_start();
    feed_run(0);
    finish_run("uniform");
    for (int n = 0; n < 20; n++)
      chk(got[n] == 0, "R6", $sformatf("leading unseen code %0d", n), got[n], 0);
    for (int n = 100; n < NBINS; n++)
      chk(got[n] == got[99], "R6", $sformatf("trailing unseen code %0d", n), got[n], got[99]);
    d = got[59] - (40 * FULL) / 80;
    chk(d < 40 && d > -40, "R5", "uniform midpoint near half period", got[59], (40 * FULL) / 80);

    pulse_start();
    chk(done == 1'b0, "R2", "start drops done", done, 0);

    // Heavy periodic bins, then an abandoned accumulation (R2) before the single-code run (R9).
    feed_run(1);
    finish_run("periodic");

    pulse_start();
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      code_valid = 1'b1;
      code_in = CODE_W'(5);
    end
    pulse_start();
    feed_run(2);
    finish_run("single64");
    chk(got[5] == 0, "R2", "abandoned run counts cleared", got[5], 0);
    chk(got[63] == 0 && got[64] == FULL - 1, "R9", "step at code 64 with clamp",
        got[64], FULL - 1);

    // Run abandoned during its write phase, then all hits on the top code.
    pulse_start();
    feed_run(4);
    repeat (10) @(negedge clk);
    pulse_start();
    feed_run(3);
    finish_run("top_code");
    chk(got[NBINS-2] == 0 && got[NBINS-1] == FULL - 1, "R9", "write-phase abort leaves no trace",
        got[NBINS-2], 0);

    // Full-range random run.
    pulse_start();
    feed_run(4);
    finish_run("random");

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule